// File: doc/BRIEF.md
# Interrupt Trigger Front End

This block sits in front of an interrupt distributor and turns raw interrupt inputs into per-ID "asserted" events. It covers three interrupt classes. IDs 0 to 15 are software-generated requests and are always edge-triggered. IDs 25 to 31 are seven private peripheral lines; these are level-sensitive and have a fixed polarity per line. IDs 32 and up are shared lines, and each one's trigger mode can be programmed. The downstream pending and active logic reads only the event vector, so the polarity and mode choices stay inside this block.

Software reaches the block through a 32-bit word-addressed register port. Each ID has a 2-bit configuration field. A set of read-only raw-status words returns the true current level of the private and shared input pins, whatever any pending state elsewhere holds. A lock input write-protects the trigger mode of the lowest-numbered shared interrupts.

The register port has no back-pressure. Every write and read strobe is accepted in the cycle it is presented, and a read answers one cycle later with `rvalid`. The raw inputs are sampled on every clock, and the event vector is fresh each cycle. Nothing downstream can stall the block.

Top module: `irq_trig_front`

## Requirements
- R1: The configuration word at address 0 (IDs 0 to 15) always reads 0xAAAAAAAA, meaning every field is b10 (edge). Writes to it change nothing.
- R2: The configuration word at address 1 always reads 0x55540000. IDs 25 to 31 read b01 (level) and IDs 16 to 24 read b00. Writes to it change nothing.
- R3: Shared line n has its field at address 2 + n/16, bits [2(n%16)+1 : 2(n%16)]. The low bit always reads 1. The high bit is writable: 0 selects level mode and 1 selects rising-edge mode. Reset clears every high bit.
- R4: Fields for shared lines at or above N_SHARED read b00 and ignore writes.
- R5: While `cfg_lock` is high, writes leave the high bit of shared lines 0 to N_LOCK-1 unchanged. Other shared lines in the same word still take the write.
- R6: Address 32 returns the raw `ppi_in` levels in bits [15:9], with line k at bit 9+k. All other bits read 0.
- R7: Address 40+j (j = 0 to 6) returns `spi_in[32j+b]` in bit b. Bits for unimplemented lines read 0.
- R8: The event for ID 25+k follows the conditioned level of `ppi_in[k]`. Lines 0 to 5 are active-low and line 6 is active-high. IDs 16 to 24 never raise an event.
- R9: A shared line in level mode raises its event in every cycle where its registered sample is 1.
- R10: A shared line in edge mode raises a one-cycle event when its sample goes from 0 to 1. A mode change takes effect in the cycle after the write.
- R11: IDs 0 to 15 raise a one-cycle event on each rising edge of `sgi_in`.
- R12: A read returns data in the cycle after the strobe, with `rvalid` high for that one cycle. `rdata` is 0 in cycles that follow no read.
- R13: Unmapped addresses read 0, and writes to them change nothing.

Event timing: an input sampled at clock edge t shows up on `evt` right after edge t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| rvalid | output | 1 | Read data valid |
| cfg_lock | input | 1 | Write-protect for lockable shared modes |
| sgi_in | input | 16 | Software-generated request lines |
| ppi_in | input | 7 | Private peripheral lines, raw polarity |
| spi_in | input | N_SHARED | Shared peripheral lines |
| evt | output | 32+N_SHARED | Per-ID trigger event vector |

## Verification
The bench checks how the lock boundary splits a single word between protected and free lines. A design that compared against the wrong count would block line N_LOCK or let line N_LOCK-1 through. It also probes the partial last configuration word and the partial last status word. A design that ignored N_SHARED would return phantom 1s in the low bits of those fields. The event vector is compared every cycle while mode writes, lock toggles and random inputs are mixed. An inverted polarity mask, a level line that pulses, an edge that holds high, or a mode change one cycle late each shows up as a mismatch on the affected ID.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  localparam int unsigned WORD_W         = 32;
  localparam int unsigned SGI_COUNT      = 16;
  localparam int unsigned PPI_COUNT      = 7;
  localparam int unsigned PPI_FIRST_ID   = 25;
  localparam int unsigned SHARED_BASE_ID = 32;
  localparam int unsigned MAX_SHARED     = 224;
  localparam int unsigned CFG_WORDS      = 16;
  localparam int unsigned FLD_PER_WORD   = 16;

  // lines 0..5 are active-low, line 6 active-high
  localparam logic [PPI_COUNT-1:0] PPI_ACT_LOW = 7'b011_1111;

  localparam logic [5:0] PPI_STAT_WA = 6'd32;
  localparam logic [5:0] SPI_STAT_WA = 6'd40;

  localparam logic [1:0] CODE_EDGE_FIXED  = 2'b10;
  localparam logic [1:0] CODE_LEVEL_FIXED = 2'b01;
  localparam logic [1:0] CODE_ABSENT      = 2'b00;

  typedef enum logic [1:0] {
    RG_CFG,
    RG_PPI_STAT,
    RG_SPI_STAT,
    RG_NONE
  } reg_grp_e;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import irq_trig_pkg::*;
#(
  parameter int unsigned N_SHARED = 40,
  parameter int unsigned N_LOCK   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [5:0]          addr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                cfg_lock,
  output logic [N_SHARED-1:0] mode_hi
);
  // even bits of each field are read-only; fold them away
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar g = 0; g < N_SHARED; g++) begin : g_line
    localparam int unsigned WA  = 2 + g / FLD_PER_WORD;
    localparam int unsigned FB  = 2 * (g % FLD_PER_WORD) + 1;
    localparam bit          LCK = (g < N_LOCK);
    logic hit;
    logic bit_q;
    if (LCK) begin : g_lockable
      assign hit = wr_en && (addr == 6'(WA)) && !cfg_lock;
    end else begin : g_free
      assign hit = wr_en && (addr == 6'(WA));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bit_q <= 1'b0;
      else if (hit) bit_q <= wdata[FB];
    end
    assign mode_hi[g] = bit_q;
  end
endmodule

// File: rtl/trig_cond.sv
module trig_cond
  import irq_trig_pkg::*;
#(
  parameter int unsigned N_SHARED = 40
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [SGI_COUNT-1:0]               sgi_in,
  input  logic [PPI_COUNT-1:0]               ppi_in,
  input  logic [N_SHARED-1:0]                spi_in,
  input  logic [N_SHARED-1:0]                mode_hi,
  output logic [SHARED_BASE_ID+N_SHARED-1:0] evt
);
  localparam int unsigned NUM_ID = SHARED_BASE_ID + N_SHARED;

  logic [NUM_ID-1:0] cond;
  logic [NUM_ID-1:0] edge_sel;
  logic [NUM_ID-1:0] cur_q;
  logic [NUM_ID-1:0] prev_q;

  always_comb begin
    cond = '0;
    cond[SGI_COUNT-1:0]               = sgi_in;
    cond[PPI_FIRST_ID +: PPI_COUNT]   = ppi_in ^ PPI_ACT_LOW;
    cond[SHARED_BASE_ID +: N_SHARED]  = spi_in;
  end

  for (genvar id = 0; id < NUM_ID; id++) begin : g_sel
    if (id < SGI_COUNT) begin : g_sgi
      assign edge_sel[id] = 1'b1;
    end else if (id < SHARED_BASE_ID) begin : g_priv
      assign edge_sel[id] = 1'b0;
    end else begin : g_shr
      assign edge_sel[id] = mode_hi[id - SHARED_BASE_ID];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= cond;
      prev_q <= cur_q;
    end
  end

  // edge lines mask out a sample that was already high last cycle
  assign evt = cur_q & ~(prev_q & edge_sel);
endmodule

// File: rtl/trig_readmux.sv
module trig_readmux
  import irq_trig_pkg::*;
#(
  parameter int unsigned N_SHARED = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [5:0]          addr,
  input  logic [N_SHARED-1:0] mode_hi,
  input  logic [PPI_COUNT-1:0] ppi_in,
  input  logic [N_SHARED-1:0] spi_in,
  output logic [WORD_W-1:0]   rdata,
  output logic                rvalid
);
  localparam int unsigned CFG_BITS = CFG_WORDS * WORD_W;

  logic [CFG_BITS-1:0]   cfg_flat;
  logic [MAX_SHARED-1:0] spi_pad;
  logic [WORD_W-1:0]     word_sel;
  reg_grp_e              grp;

  assign spi_pad = MAX_SHARED'(spi_in);

  for (genvar k = 0; k < CFG_WORDS; k++) begin : g_word
    for (genvar j = 0; j < FLD_PER_WORD; j++) begin : g_fld
      localparam int unsigned ID = k * FLD_PER_WORD + j;
      localparam int unsigned LO = k * WORD_W + 2 * j;
      if (ID < SGI_COUNT) begin : g_sgi
        assign cfg_flat[LO +: 2] = CODE_EDGE_FIXED;
      end else if (ID >= PPI_FIRST_ID && ID < SHARED_BASE_ID) begin : g_ppi
        assign cfg_flat[LO +: 2] = CODE_LEVEL_FIXED;
      end else if (ID >= SHARED_BASE_ID && ID < SHARED_BASE_ID + N_SHARED) begin : g_shr
        assign cfg_flat[LO +: 2] = {mode_hi[ID - SHARED_BASE_ID], 1'b1};
      end else begin : g_none
        assign cfg_flat[LO +: 2] = CODE_ABSENT;
      end
    end
  end

  always_comb begin
    grp = RG_NONE;
    if (addr[5:4] == 2'b00)                                     grp = RG_CFG;
    else if (addr == PPI_STAT_WA)                               grp = RG_PPI_STAT;
    else if (addr[5:3] == SPI_STAT_WA[5:3] && addr[2:0] != 3'b111) grp = RG_SPI_STAT;
  end

  always_comb begin
    unique case (grp)
      RG_CFG:      word_sel = cfg_flat[{addr[3:0], 5'b0} +: WORD_W];
      RG_PPI_STAT: word_sel = {16'b0, ppi_in, 9'b0};
      RG_SPI_STAT: word_sel = spi_pad[{addr[2:0], 5'b0} +: WORD_W];
      default:     word_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      rdata  <= rd_en ? word_sel : '0;
    end
  end
endmodule

// File: rtl/irq_trig_front.sv
module irq_trig_front
  import irq_trig_pkg::*;
#(
  parameter int unsigned N_SHARED = 40,
  parameter int unsigned N_LOCK   = 12
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic                               rd_en,
  input  logic [5:0]                         addr,
  input  logic [31:0]                        wdata,
  output logic [31:0]                        rdata,
  output logic                               rvalid,
  input  logic                               cfg_lock,
  input  logic [15:0]                        sgi_in,
  input  logic [6:0]                         ppi_in,
  input  logic [N_SHARED-1:0]                spi_in,
  output logic [SHARED_BASE_ID+N_SHARED-1:0] evt
);
  logic [N_SHARED-1:0] mode_hi;

  trig_cfg_regs #(.N_SHARED(N_SHARED), .N_LOCK(N_LOCK)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .cfg_lock (cfg_lock),
    .mode_hi  (mode_hi)
  );

  trig_cond #(.N_SHARED(N_SHARED)) u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .sgi_in  (sgi_in),
    .ppi_in  (ppi_in),
    .spi_in  (spi_in),
    .mode_hi (mode_hi),
    .evt     (evt)
  );

  trig_readmux #(.N_SHARED(N_SHARED)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .mode_hi (mode_hi),
    .ppi_in  (ppi_in),
    .spi_in  (spi_in),
    .rdata   (rdata),
    .rvalid  (rvalid)
  );
endmodule

// File: rtl/irq_trig_front_chk.sv
module irq_trig_front_chk #(
  parameter int unsigned N_SHARED = 40,
  parameter int unsigned N_LOCK   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_en,
  input logic [5:0]          addr,
  input logic [31:0]         rdata,
  input logic                rvalid,
  input logic                cfg_lock,
  input logic [6:0]          ppi_in,
  input logic [N_SHARED-1:0] spi_in,
  input logic [15:0]         evt_sgi,
  input logic [6:0]          evt_ppi,
  input logic [N_SHARED-1:0] mode_hi
);
  localparam int unsigned W0 = (N_SHARED < 32) ? N_SHARED : 32;

  logic        past_ok;
  logic [31:0] stat0_exp;
  logic        unused_chk;

  assign stat0_exp  = 32'(spi_in[W0-1:0]);
  assign unused_chk = ^{spi_in, mode_hi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  sgi_cfg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 6'd0 |=> rdata == 32'hAAAA_AAAA);

  // R12
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> rvalid == $past(rd_en));

  // R12
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == 32'h0);

  // R8
  ppi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> evt_ppi == $past(ppi_in ^ 7'b011_1111));

  // R11
  sgi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (evt_sgi & $past(evt_sgi)) == 16'h0);

  // R7
  spi_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 6'd40 |=> rdata == $past(stat0_exp));

  if (N_LOCK > 0) begin : g_lock
    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_lock |=> $stable(mode_hi[N_LOCK-1:0]));
  end
endmodule

bind irq_trig_front irq_trig_front_chk #(.N_SHARED(N_SHARED), .N_LOCK(N_LOCK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .rvalid   (rvalid),
  .cfg_lock (cfg_lock),
  .ppi_in   (ppi_in),
  .spi_in   (spi_in),
  .evt_sgi  (evt[15:0]),
  .evt_ppi  (evt[31:25]),
  .mode_hi  (mode_hi)
);

// File: tb/sim_irq_trig_front.sv
module sim_irq_trig_front;
  localparam int unsigned NS  = 40;
  localparam int unsigned NL  = 12;
  localparam int unsigned NID = 32 + NS;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0, rd_en = 1'b0, cfg_lock = 1'b0;
  logic [5:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic [15:0]    sgi_in = '0;
  logic [6:0]     ppi_in = 7'h3F;
  logic [NS-1:0]  spi_in = '0;
  logic [31:0]    rdata;
  logic           rvalid;
  logic [NID-1:0] evt;

  int  errs = 0, checks = 0;
  bit  done = 1'b0, evt_on = 1'b0;
  bit  mode_m [NS];
  logic [NID-1:0] cur_m = '0, prev_m = '0;

  always #4 clk = ~clk;

  irq_trig_front #(.N_SHARED(NS), .N_LOCK(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .cfg_lock(cfg_lock),
    .sgi_in(sgi_in), .ppi_in(ppi_in), .spi_in(spi_in), .evt(evt));

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [NID-1:0] cond_now();
    logic [NID-1:0] v = '0;
    v[15:0]  = sgi_in;
    v[31:25] = ppi_in ^ 7'b011_1111;
    v[32 +: NS] = spi_in;
    return v;
  endfunction

  function automatic logic [NID-1:0] exp_evt();
    logic [NID-1:0] e;
    for (int i = 0; i < NID; i++) begin
      if (i < 16)      e[i] = cur_m[i] & ~prev_m[i];
      else if (i < 32) e[i] = (i >= 25) ? cur_m[i] : 1'b0;
      else             e[i] = mode_m[i-32] ? (cur_m[i] & ~prev_m[i]) : cur_m[i];
    end
    return e;
  endfunction

  function automatic logic [31:0] cfg_exp(int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 16; j++) begin
      int id = k * 16 + j;
      if (id < 16)                     w[2*j +: 2] = 2'b10;
      else if (id >= 25 && id < 32)    w[2*j +: 2] = 2'b01;
      else if (id >= 32 && id < 32+NS) w[2*j +: 2] = {mode_m[id-32], 1'b1};
    end
    return w;
  endfunction

  function automatic logic [31:0] stat_exp(logic [5:0] a);
    logic [223:0] pad = 224'(spi_in);
    if (a == 6'd32) return {16'b0, ppi_in, 9'b0};
    if (a >= 6'd40 && a <= 6'd46) return pad[(int'(a) - 40) * 32 +: 32];
    if (a < 6'd16) return cfg_exp(int'(a));
    return 32'h0;
  endfunction

  task automatic step();
    @(posedge clk);
    prev_m = cur_m;
    cur_m  = cond_now();
    if (wr_en && addr >= 6'd2 && addr < 6'd16)
      for (int j = 0; j < 16; j++) begin
        int n = (int'(addr) - 2) * 16 + j;
        if (n < NS && !(cfg_lock && n < NL)) mode_m[n] = wdata[2*j+1];
      end
    @(negedge clk);
    if (evt_on) begin
      logic [NID-1:0] e = exp_evt();
      checks++;
      if (evt !== e) begin
        int bad = 0;
        string rq;
        for (int i = NID - 1; i >= 0; i--) if (evt[i] !== e[i]) bad = i;
        rq = (bad < 16) ? "R11" : (bad < 32) ? "R8" : mode_m[bad-32] ? "R10" : "R9";
        errs++;
        $display("FAIL %s evt[%0d]: actual=%h expected=%h", rq, bad, evt, e);
      end
    end
  endtask

  task automatic wr_reg(logic [5:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [5:0] a, logic [31:0] exp, string req);
    rd_en = 1'b1; addr = a;
    step();
    rd_en = 1'b0;
    chk(rvalid === 1'b1, "R12", "rvalid", 64'(rvalid), 64'h1);
    chk(rdata === exp, req, $sformatf("rdata@%0d", a), 64'(rdata), 64'(exp));
  endtask

  initial begin
    for (int i = 0; i < NS; i++) mode_m[i] = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(rdata === 32'h0 && rvalid === 1'b0, "R12", "reset rd", {rdata, 31'b0, rvalid}, 64'h0);
    chk(evt === '0, "R9", "reset evt", 64'(evt), 64'h0);
    rst_n = 1'b1;
    evt_on = 1'b1;

    // R1 fixed software-generated codes
    rd_chk(6'd0, 32'hAAAA_AAAA, "R1");
    wr_reg(6'd0, 32'h0);
    rd_chk(6'd0, 32'hAAAA_AAAA, "R1");
    // R2 fixed private codes
    wr_reg(6'd1, 32'hFFFF_FFFF);
    rd_chk(6'd1, 32'h5554_0000, "R2");
    // R3 shared mode bits
    rd_chk(6'd2, 32'h5555_5555, "R3");
    wr_reg(6'd2, 32'hFFFF_FFFF);
    rd_chk(6'd2, 32'hFFFF_FFFF, "R3");
    wr_reg(6'd2, 32'h0);
    rd_chk(6'd2, 32'h5555_5555, "R3");
    // R4 partial word and absent words
    rd_chk(6'd4, 32'h0000_5555, "R4");
    wr_reg(6'd4, 32'hFFFF_FFFF);
    rd_chk(6'd4, 32'h0000_FFFF, "R4");
    rd_chk(6'd5, 32'h0, "R4");
    // R5 lock boundary inside word 2
    cfg_lock = 1'b1;
    wr_reg(6'd2, 32'hFFFF_FFFF);
    rd_chk(6'd2, 32'hFF55_5555, "R5");
    wr_reg(6'd3, 32'hFFFF_FFFF);
    rd_chk(6'd3, 32'hFFFF_FFFF, "R5");
    cfg_lock = 1'b0;
    wr_reg(6'd2, 32'hFFFF_FFFF);
    rd_chk(6'd2, 32'hFFFF_FFFF, "R5");
    // R13 unmapped
    wr_reg(6'd33, 32'h0);
    rd_chk(6'd2, 32'hFFFF_FFFF, "R13");
    rd_chk(6'd33, 32'h0, "R13");
    rd_chk(6'd47, 32'h0, "R13");
    rd_chk(6'd63, 32'h0, "R13");
    step();
    chk(rvalid === 1'b0 && rdata === 32'h0, "R12", "idle after read", {rdata, 31'b0, rvalid}, 64'h0);

    // R10 edge on shared 0 (edge mode now)
    spi_in[0] = 1'b1; step();
    chk(evt[32] === 1'b1, "R10", "edge first", 64'(evt[32]), 64'h1);
    step();
    chk(evt[32] === 1'b0, "R10", "edge held", 64'(evt[32]), 64'h0);
    // R9 level on shared 1
    wr_reg(6'd2, 32'h0);
    spi_in[1] = 1'b1; step(); step();
    chk(evt[33] === 1'b1, "R9", "level held", 64'(evt[33]), 64'h1);
    // R8 polarity
    ppi_in = 7'h3E; step();
    chk(evt[31:16] === 16'h0200, "R8", "ppi0 low", 64'(evt[31:16]), 64'h0200);
    ppi_in = 7'h7F; step();
    chk(evt[31:16] === 16'h8000, "R8", "ppi6 high", 64'(evt[31:16]), 64'h8000);
    ppi_in = 7'h3F; step();
    chk(evt[31:16] === 16'h0, "R8", "ppi idle", 64'(evt[31:16]), 64'h0);
    // R11 software-generated edge
    sgi_in[3] = 1'b1; step();
    chk(evt[3] === 1'b1, "R11", "sgi rise", 64'(evt[3]), 64'h1);
    step();
    chk(evt[3] === 1'b0, "R11", "sgi held", 64'(evt[3]), 64'h0);
    // R6 / R7 raw status
    ppi_in = 7'h55;
    rd_chk(6'd32, 32'h0000_AA00, "R6");
    spi_in = 40'hA5_1234_5678;
    rd_chk(6'd40, 32'h1234_5678, "R7");
    rd_chk(6'd41, 32'h0000_00A5, "R7");
    rd_chk(6'd42, 32'h0, "R7");

    // random mix: R3 R5 R9 R10 R11 R8 R7 R6
    for (int it = 0; it < 800; it++) begin
      int op = $urandom_range(0, 5);
      sgi_in = 16'($urandom) & 16'($urandom);
      ppi_in = 7'($urandom);
      spi_in = NS'({$urandom, $urandom});
      cfg_lock = 1'($urandom);
      if (op == 0) wr_reg(6'($urandom_range(0, 15)), $urandom);
      else if (op == 1) begin
        logic [5:0] a = 6'($urandom_range(0, 47));
        logic [31:0] ex = stat_exp(a);
        rd_chk(a, ex, (a < 6'd16) ? "R3" : (a == 6'd32) ? "R6" : (a >= 6'd40) ? "R7" : "R13");
      end else step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule